// File: doc/BRIEF.md
# Halt-Mode Clock and Wake Controller

This block runs the halt variant of a microcontroller's low-power entry. When the core strobes a STOP request and the halt option is set, the block removes the processor clock enable. All core and bus activity is then frozen. The clock enable for the timer and watchdog stays on, so those keep counting. On entry the block sends a one-cycle pulse that clears the core's interrupt mask, so that an external interrupt can wake the part.

A wake source restarts the processor clock. That source is an external IRQ, or a timer interrupt whose enable is set. The restart does not happen at once: the block waits for the next terminal count of an oscillator-stabilization counter. That counter never stops running, so the exit delay depends on where the counter happens to be, and lies anywhere from 1 to 4064 cycles. A wake is held as pending while the block waits, so a single-cycle request is enough. A STOP strobe with the halt option clear is not handled here. It is forwarded on a separate request output for the true stop logic.

Top module: `halt_wake_ctrl`

## Requirements
- R1: In RUN, a cycle with `stop_strobe`=1 and `halt_opt`=1 moves the block to HALT at the next clock edge. From that edge `core_clk_en` is 0 and `mode` is 2'b01.
- R2: `periph_clk_en` is 1 in every cycle, including reset, halt and wake-pending.
- R3: `mask_clr` is high for exactly one cycle, directly after the clock edge that enters HALT. It is low in all other cycles.
- R4: In HALT, `ext_irq`=1 is a wake event.
- R5: In HALT, `tmr_irq`=1 is a wake event only while `tmr_ie`=1. With `tmr_ie`=0 the block stays in HALT, `mode`=2'b01 and `core_clk_en`=0.
- R6: The stabilization counter counts 0 to STAB_PERIOD-1 (default 4064) and wraps. Only reset clears it to 0; halt entry and halt exit leave it running. The terminal count is STAB_PERIOD-1. `core_clk_en` returns to 1 at the clock edge that ends the first cycle at or after the wake event in which the counter is at its terminal count. The delay is therefore 1 to STAB_PERIOD cycles.
- R7: A wake event that arrives when the counter is not at its terminal count is latched as pending (`mode`=2'b10, `core_clk_en`=0). The pending state is held until the terminal count, even if the wake input drops after a single cycle.
- R8: While `rst`=1, at each clock edge the block is forced to RUN with `core_clk_en`=1, `mode`=2'b00, any pending wake is cleared and the counter is reset to 0.
- R9: In RUN, a cycle with `stop_strobe`=1 and `halt_opt`=0 gives a one-cycle pulse on `stop_req` after the next edge, and the block stays in RUN.
- R10: `mode` encodes RUN=2'b00, HALT=2'b01 and WAKE_PENDING=2'b10. The value 2'b11 never appears. `core_clk_en` is 1 exactly when `mode` is RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_strobe | input | 1 | One-cycle STOP request from the core |
| halt_opt | input | 1 | Option bit that turns STOP into halt |
| tmr_irq | input | 1 | Timer interrupt request |
| tmr_ie | input | 1 | Timer interrupt enable |
| ext_irq | input | 1 | External interrupt request |
| core_clk_en | output | 1 | Processor phase clock enable |
| periph_clk_en | output | 1 | Timer and watchdog clock enable |
| mask_clr | output | 1 | One-cycle pulse that clears the interrupt mask bit |
| stop_req | output | 1 | One-cycle forward of a STOP that is not converted to halt |
| mode | output | 2 | Operating state: 00 RUN, 01 HALT, 10 WAKE_PENDING |

## Verification
A wrong state register shows up on `mode` and `core_clk_en` at the edge right after the faulty transition. Examples are a missed entry, a wake taken while the timer enable is off, or a pending wake that is dropped. A fault in the stabilization counter or its terminal compare stays hidden until a release. It can therefore take up to 4064 cycles to reach the ports, so the bench aligns wake events to the counter's known phase since reset. It measures both the 1-cycle and the 4064-cycle exit.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

    typedef enum logic [1:0] {
        HWC_RUN  = 2'b00,
        HWC_HALT = 2'b01,
        HWC_WAKE = 2'b10
    } hwc_mode_e;

    typedef struct packed {
        logic tmr_req;
        logic tmr_en;
        logic ext_req;
    } hwc_wake_src_t;

    function automatic logic wake_hit(input hwc_wake_src_t s);
        return s.ext_req | (s.tmr_req & s.tmr_en);
    endfunction

endpackage

// File: rtl/hwc_stab_counter.sv
module hwc_stab_counter #(
    parameter int unsigned PERIOD = 4064
) (
    input  logic clk,
    input  logic rst,
    output logic tc
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    // Free-running; only reset touches it, never the halt logic.
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tc = (cnt == LAST);
endmodule

// File: rtl/hwc_halt_fsm.sv
module hwc_halt_fsm
    import hwc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          stop_strobe,
    input  logic          halt_opt,
    input  hwc_wake_src_t src,
    input  logic          tc,
    output hwc_mode_e     mode_q,
    output logic          mask_clr,
    output logic          stop_req
);
    hwc_mode_e mode_d;
    logic      wake;
    logic      enter;
    logic      fwd;

    assign wake  = wake_hit(src);
    assign enter = (mode_q == HWC_RUN) && stop_strobe && halt_opt;
    assign fwd   = (mode_q == HWC_RUN) && stop_strobe && !halt_opt;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            HWC_RUN:  if (enter) mode_d = HWC_HALT;
            HWC_HALT: if (wake)  mode_d = tc ? HWC_RUN : HWC_WAKE;
            HWC_WAKE: if (tc)    mode_d = HWC_RUN;
            default:             mode_d = HWC_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= HWC_RUN;
            mask_clr <= 1'b0;
            stop_req <= 1'b0;
        end else begin
            mode_q   <= mode_d;
            mask_clr <= enter;
            stop_req <= fwd;
        end
    end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import hwc_pkg::*;
#(
    parameter int unsigned STAB_PERIOD = 4064
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_strobe,
    input  logic       halt_opt,
    input  logic       tmr_irq,
    input  logic       tmr_ie,
    input  logic       ext_irq,
    output logic       core_clk_en,
    output logic       periph_clk_en,
    output logic       mask_clr,
    output logic       stop_req,
    output logic [1:0] mode
);
    logic          stab_tc;
    hwc_mode_e     mode_q;
    hwc_wake_src_t src;

    assign src = '{tmr_req: tmr_irq, tmr_en: tmr_ie, ext_req: ext_irq};

    hwc_stab_counter #(.PERIOD(STAB_PERIOD)) u_stab (
        .clk (clk),
        .rst (rst),
        .tc  (stab_tc)
    );

    hwc_halt_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .stop_strobe (stop_strobe),
        .halt_opt    (halt_opt),
        .src         (src),
        .tc          (stab_tc),
        .mode_q      (mode_q),
        .mask_clr    (mask_clr),
        .stop_req    (stop_req)
    );

    assign core_clk_en   = (mode_q == HWC_RUN);
    assign periph_clk_en = 1'b1;
    assign mode          = mode_q;
endmodule

// File: rtl/hwc_checker.sv
module hwc_checker
    import hwc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       stop_strobe,
    input logic       halt_opt,
    input logic       tmr_irq,
    input logic       tmr_ie,
    input logic       ext_irq,
    input logic       tc,
    input logic [1:0] mode,
    input logic       core_clk_en,
    input logic       mask_clr,
    input logic       stop_req
);
    localparam logic [1:0] M_RUN  = 2'b00;
    localparam logic [1:0] M_HALT = 2'b01;
    localparam logic [1:0] M_WAKE = 2'b10;

    a_r1_halt_entry: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RUN && stop_strobe && halt_opt) |=> (mode == M_HALT && !core_clk_en));

    a_r3_mask_on_entry: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RUN && stop_strobe && halt_opt) |=> mask_clr);

    a_r3_mask_single: assert property (@(posedge clk) disable iff (rst)
        mask_clr |=> !mask_clr);

    a_r4_ext_wake: assert property (@(posedge clk) disable iff (rst)
        (mode == M_HALT && ext_irq) |=> (mode != M_HALT));

    a_r5_tmr_masked: assert property (@(posedge clk) disable iff (rst)
        (mode == M_HALT && tmr_irq && !tmr_ie && !ext_irq) |=> (mode == M_HALT));

    a_r6_release_tc: assert property (@(posedge clk) disable iff (rst)
        (mode == M_WAKE && tc) |=> (mode == M_RUN && core_clk_en));

    a_r7_pending_hold: assert property (@(posedge clk) disable iff (rst)
        (mode == M_WAKE && !tc) |=> (mode == M_WAKE));

    a_r8_reset_run: assert property (@(posedge clk)
        rst |=> (mode == M_RUN && core_clk_en && !mask_clr && !stop_req));

    a_r9_stop_forward: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RUN && stop_strobe && !halt_opt) |=> (stop_req && mode == M_RUN));

    a_r10_mode_legal: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b11) && (core_clk_en == (mode == M_RUN)));
endmodule

bind halt_wake_ctrl hwc_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .stop_strobe (stop_strobe),
    .halt_opt    (halt_opt),
    .tmr_irq     (tmr_irq),
    .tmr_ie      (tmr_ie),
    .ext_irq     (ext_irq),
    .tc          (stab_tc),
    .mode        (mode),
    .core_clk_en (core_clk_en),
    .mask_clr    (mask_clr),
    .stop_req    (stop_req)
);

// File: tb/sim_halt_wake_ctrl.sv
`timescale 1ns/100ps
module sim_halt_wake_ctrl;
    localparam int PERIOD = 4064;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_strobe = 1'b0, halt_opt = 1'b0;
    logic tmr_irq = 1'b0, tmr_ie = 1'b0, ext_irq = 1'b0;
    logic core_clk_en, periph_clk_en, mask_clr, stop_req;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state: 0 RUN, 1 HALT, 2 WAKE_PENDING
    int m_st = 0;
    int m_cnt = 0;
    bit m_mask = 0;
    bit m_sreq = 0;

    always #2.5 clk = ~clk;

    halt_wake_ctrl u0 (
        .clk(clk), .rst(rst), .stop_strobe(stop_strobe), .halt_opt(halt_opt),
        .tmr_irq(tmr_irq), .tmr_ie(tmr_ie), .ext_irq(ext_irq),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en),
        .mask_clr(mask_clr), .stop_req(stop_req), .mode(mode)
    );

    always @(posedge clk) begin
        bit at_tc;
        bit wk;
        cycles++;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_mask = 0; m_sreq = 0;
        end else begin
            at_tc  = (m_cnt == PERIOD - 1);
            wk     = ext_irq || (tmr_irq && tmr_ie);
            m_mask = (m_st == 0) && stop_strobe && halt_opt;
            m_sreq = (m_st == 0) && stop_strobe && !halt_opt;
            if (m_st == 0) begin
                if (stop_strobe && halt_opt) m_st = 1;
            end else if (m_st == 1) begin
                if (wk) m_st = at_tc ? 0 : 2;
            end else begin
                if (at_tc) m_st = 0;
            end
            m_cnt = at_tc ? 0 : m_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        check(core_clk_en == (m_st == 0), "R1 R6 core_clk_en vs model", core_clk_en, m_st == 0);
        check(mode == 2'(m_st), "R10 mode vs model", mode, m_st);
        check(mask_clr == m_mask, "R3 mask_clr vs model", mask_clr, m_mask);
        check(stop_req == m_sreq, "R9 stop_req vs model", stop_req, m_sreq);
        check(periph_clk_en == 1'b1, "R2 periph_clk_en", periph_clk_en, 1);
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic enter_halt();
        stop_strobe = 1; halt_opt = 1;
        step();
        stop_strobe = 0;
    endtask

    task automatic wait_cnt(input int v);
        do step(); while (m_cnt != v);
    endtask

    // wake input already applied; counts edges until core clock returns
    task automatic measure(output int n);
        n = 0;
        forever begin
            @(posedge clk); n++;
            #1;
            ext_irq = 0; tmr_irq = 0;
            if (core_clk_en || n > PERIOD + 10) break;
        end
    endtask

    initial begin
        cycles = 0;
        wait (cycles > 190000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<190000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) step();
        check(core_clk_en && mode == 2'b00, "R8 reset state", mode, 0);
        rst = 0;
        repeat (5) step();

        // R9: STOP without halt option is forwarded
        stop_strobe = 1; halt_opt = 0;
        step();
        stop_strobe = 0;
        check(stop_req == 1 && mode == 2'b00, "R9 stop_req pulse, still RUN", {stop_req, mode}, 3'b100);
        step();
        check(stop_req == 0, "R9 stop_req single cycle", stop_req, 0);

        // R1 / R3: halt entry
        enter_halt();
        check(mode == 2'b01 && !core_clk_en, "R1 halt entered", mode, 1);
        check(mask_clr == 1, "R3 mask_clr on entry", mask_clr, 1);
        step();
        check(mask_clr == 0, "R3 mask_clr one cycle", mask_clr, 0);

        // R5: timer request ignored while disabled
        tmr_irq = 1; tmr_ie = 0;
        repeat (20) step();
        check(mode == 2'b01 && !core_clk_en, "R5 timer masked keeps HALT", mode, 1);
        tmr_ie = 1;
        measure(n);
        tmr_ie = 0;
        check(core_clk_en == 1, "R5 enabled timer wakes", core_clk_en, 1);
        repeat (3) step();

        // R4 / R6 minimum delay: external wake on terminal count
        enter_halt();
        wait_cnt(PERIOD - 1);
        ext_irq = 1;
        measure(n);
        check(n == 1, "R4 R6 min exit delay", n, 1);
        repeat (3) step();

        // R6 maximum delay and R7 pending latch with one-cycle pulse
        enter_halt();
        wait_cnt(0);
        ext_irq = 1;
        step();
        ext_irq = 0;
        repeat (10) step();
        check(mode == 2'b10 && !core_clk_en, "R7 wake held pending", mode, 2);
        wait_cnt(PERIOD - 1);
        step();
        check(core_clk_en == 1 && mode == 2'b00, "R6 released after terminal count", mode, 0);

        // R6 max measured directly
        repeat (3) step();
        enter_halt();
        wait_cnt(0);
        ext_irq = 1;
        measure(n);
        check(n == PERIOD, "R6 max exit delay", n, PERIOD);
        repeat (3) step();

        // R8: reset clears pending wake and forces RUN
        enter_halt();
        wait_cnt(100);
        ext_irq = 1;
        step();
        ext_irq = 0;
        check(mode == 2'b10, "R7 pending before reset", mode, 2);
        rst = 1;
        step();
        rst = 0;
        check(core_clk_en && mode == 2'b00, "R8 reset forces RUN", mode, 0);
        enter_halt();
        repeat (PERIOD + 20) step();
        check(mode == 2'b01, "R8 pending cleared by reset", mode, 1);
        ext_irq = 1;
        measure(n);
        check(core_clk_en == 1, "R4 ext wake after reset", core_clk_en, 1);
        repeat (5) step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule